// File: doc/BRIEF.md
# NAND Bus Command Sequencer

This block turns a stream of 64-bit command words into pin activity on a raw NAND flash parallel bus. An upstream engine offers one word at a time on a valid/ready handshake. The block decodes the opcode in the low nibble. It then either updates internal state in a single cycle or runs a timed bus phase sequence. The state it can update is the timing table, the chip selection, the bus ownership and the data width. The timed sequences are a command-latch strobe or a wait.

Bus phases take their length from a table of seven 8-bit timing entries. A shared power-of-two multiplier scales every entry. A command never carries a raw cycle count. It names a table entry by a 3-bit index, and index 0 stands for a single unscaled cycle. Each command raises a one-cycle `done` pulse when it finishes. `err` accompanies that pulse when the command was refused or not recognised.

Top module: `nand_cmd_seq`

## Requirements
- R1: The opcode sits in bits [3:0]. The codes are 0 no-op, 1 timing load, 2 wait, 3 chip select, 4 command latch and 5 bus ownership.
- R2: A timing load takes its multiplier M from bits [7:4], and entry k (k = 1..7) from bits [8k+7:8k]. A phase that names index k lasts (entry+1)·2^M cycles. Index 0 always lasts exactly one cycle.
- R3: A command latch puts bits [15:8] on `nand_ad` and raises `nand_cle` for d1 cycles before `nand_we_n` falls. It then holds `nand_we_n` low for d2 cycles and keeps `nand_cle` high d3 cycles after `nand_we_n` rises. The durations come from the indices in bits [18:16], [21:19] and [24:22]. `done` rises d1+d2+d3 cycles after acceptance, and `nand_ad` stays stable while `nand_we_n` is low.
- R4: A wait first spends the duration of the index in bits [10:8]. If bit 4 is clear, it then spends one more cycle. If bit 4 is set, it stays until `nand_wait` is low. No strobe is driven during a wait.
- R5: A chip command takes the chip number from bits [6:4], the enable from bit 7 and the width code from bits [9:8]. While enabled with chip n in 1..7, `nand_ce_n[n-1]` alone is low. Chip 0 or enable 0 drives all lines high. `bus16` is 1 only for width code 10.
- R6: A bus command sets `bus_owned` to bit 4. `bus_owned` changes on no other occasion.
- R7: A latch or wait issued while the bus is not owned, or while no chip is enabled, is refused. It completes in one cycle with `err` high and no strobe.
- R8: A no-op completes in one cycle with no bus activity. Any other unlisted opcode does the same and raises `err`.
- R9: `cmd_ready` is low from acceptance of a multi-cycle command until its final phase has expired. `busy` is high over the same span. `done` pulses for one cycle per command.
- R10: After reset, all chip enables are high, `nand_cle` is 0, `nand_we_n` is 1, `nand_ad` is 0, the bus is not owned, the block is idle and ready, and the timing table and multiplier are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command word offered |
| cmd_data | input | 64 | Command word |
| cmd_ready | output | 1 | Block can take a word this cycle |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Refused or unknown command, with `done` |
| busy | output | 1 | A timed sequence is running |
| bus_owned | output | 1 | Bus currently acquired |
| bus16 | output | 1 | 16-bit data width selected |
| nand_ce_n | output | 7 | Active-low chip enables, chips 1..7 |
| nand_cle | output | 1 | Command latch enable |
| nand_we_n | output | 1 | Active-low write enable |
| nand_ad | output | 8 | Address/data pins |
| nand_wait | input | 1 | Flash ready/busy, high while busy |

## Verification
Two things can coincide in one cycle: the expiry of a wait's timing phase and the release of the ready/busy line. The second wait test holds `nand_wait` high through the timed part and drops it at a chosen cycle. It then checks that completion comes exactly one cycle later. A run with the line already low must cost the same as a flag-clear wait. A second collision pairs a refusal with the completion pulse. A latch issued right after ownership is released must give `done` and `err` in the same cycle, with zero cycles of strobe activity.

// File: rtl/nand_cmd_seq.sv
module nand_cmd_seq #(
  parameter int CNT_W = 24
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_valid,
  input  logic [63:0] cmd_data,
  output logic        cmd_ready,
  output logic        done,
  output logic        err,
  output logic        busy,
  output logic        bus_owned,
  output logic        bus16,
  output logic [6:0]  nand_ce_n,
  output logic        nand_cle,
  output logic        nand_we_n,
  output logic [7:0]  nand_ad,
  input  logic        nand_wait
);
  localparam int NSLOT = 7;

  typedef enum logic [2:0] {S_IDLE, S_CLE1, S_CLE2, S_CLE3, S_TWAIT, S_RB, S_ONE} st_t;

  st_t              st;
  logic [7:0]       slot [NSLOT];
  logic [3:0]       mult;
  logic [CNT_W-1:0] cnt;
  logic [2:0]       nxt2, nxt3, chip;
  logic             rb, chip_en;

  wire       accept = cmd_valid && cmd_ready;
  wire [3:0] op     = cmd_data[3:0];
  wire       ok     = bus_owned && chip_en && (chip != 3'd0);

  assign cmd_ready = (st == S_IDLE);
  assign busy      = (st != S_IDLE);

  for (genvar g = 0; g < NSLOT; g++) begin : g_ce
    assign nand_ce_n[g] = !(chip_en && chip == 3'(g + 1));
  end

  function automatic logic [CNT_W-1:0] dur_m1(input logic [2:0] idx);
    logic [CNT_W-1:0] d;
    if (idx == 3'd0) d = CNT_W'(1);
    else d = CNT_W'({1'b0, slot[idx - 3'd1]} + 9'd1) << mult;
    return d - CNT_W'(1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      for (int k = 0; k < NSLOT; k++) slot[k] <= '0;
      mult      <= '0;
      cnt       <= '0;
      nxt2      <= '0;
      nxt3      <= '0;
      rb        <= 1'b0;
      chip      <= '0;
      chip_en   <= 1'b0;
      bus16     <= 1'b0;
      bus_owned <= 1'b0;
      nand_cle  <= 1'b0;
      nand_we_n <= 1'b1;
      nand_ad   <= '0;
      done      <= 1'b0;
      err       <= 1'b0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      unique case (st)
        S_IDLE: if (accept) begin
          nxt2 <= cmd_data[21:19];
          nxt3 <= cmd_data[24:22];
          rb   <= cmd_data[4];
          case (op)
            4'h0: done <= 1'b1;
            4'h1: begin
              mult <= cmd_data[7:4];
              for (int k = 0; k < NSLOT; k++) slot[k] <= cmd_data[8*(k+1) +: 8];
              done <= 1'b1;
            end
            4'h2: if (!ok) begin
              done <= 1'b1;
              err  <= 1'b1;
            end else begin
              cnt <= dur_m1(cmd_data[10:8]);
              st  <= S_TWAIT;
            end
            4'h3: begin
              chip    <= cmd_data[6:4];
              chip_en <= cmd_data[7];
              bus16   <= (cmd_data[9:8] == 2'b10);
              done    <= 1'b1;
            end
            4'h4: if (!ok) begin
              done <= 1'b1;
              err  <= 1'b1;
            end else begin
              nand_cle <= 1'b1;
              nand_ad  <= cmd_data[15:8];
              cnt      <= dur_m1(cmd_data[18:16]);
              st       <= S_CLE1;
            end
            4'h5: begin
              bus_owned <= cmd_data[4];
              done      <= 1'b1;
            end
            default: begin
              done <= 1'b1;
              err  <= 1'b1;
            end
          endcase
        end
        S_CLE1: if (cnt == '0) begin
          nand_we_n <= 1'b0;
          cnt       <= dur_m1(nxt2);
          st        <= S_CLE2;
        end else cnt <= cnt - 1'b1;
        S_CLE2: if (cnt == '0) begin
          nand_we_n <= 1'b1;
          cnt       <= dur_m1(nxt3);
          st        <= S_CLE3;
        end else cnt <= cnt - 1'b1;
        S_CLE3: if (cnt == '0) begin
          nand_cle <= 1'b0;
          done     <= 1'b1;
          st       <= S_IDLE;
        end else cnt <= cnt - 1'b1;
        S_TWAIT: if (cnt == '0) st <= rb ? S_RB : S_ONE;
                 else cnt <= cnt - 1'b1;
        S_RB: if (!nand_wait) begin
          done <= 1'b1;
          st   <= S_IDLE;
        end
        S_ONE: begin
          done <= 1'b1;
          st   <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/nand_cmd_seq_chk.sv
module nand_cmd_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_valid,
  input logic       cmd_ready,
  input logic [3:0] cmd_op,
  input logic       done,
  input logic       busy,
  input logic       bus_owned,
  input logic [6:0] nand_ce_n,
  input logic       nand_cle,
  input logic       nand_we_n,
  input logic [7:0] nand_ad
);
  // R3
  we_in_cle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !nand_we_n |-> nand_cle);

  // R3
  ad_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!nand_we_n && !$past(nand_we_n)) |-> $stable(nand_ad));

  // R7
  strobe_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (nand_cle || !nand_we_n) |-> (bus_owned && !(&nand_ce_n)));

  // R5
  ce_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~nand_ce_n));

  // R6
  bus_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_owned != $past(bus_owned)) |-> $past(cmd_valid && cmd_ready && cmd_op == 4'h5));

  // R9
  done_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
endmodule

bind nand_cmd_seq nand_cmd_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_op(cmd_data[3:0]), .done(done), .busy(busy), .bus_owned(bus_owned),
  .nand_ce_n(nand_ce_n), .nand_cle(nand_cle), .nand_we_n(nand_we_n), .nand_ad(nand_ad)
);

// File: tb/sim_nand_cmd_seq.sv
module sim_nand_cmd_seq;
  logic clk = 1'b0, rst_n = 1'b0, cmd_valid = 1'b0, nand_wait = 1'b0;
  logic [63:0] cmd_data = '0;
  logic cmd_ready, done, err, busy, bus_owned, bus16, nand_cle, nand_we_n;
  logic [6:0] nand_ce_n;
  logic [7:0] nand_ad;
  int nchk = 0, nbad = 0;

  always #2.5 clk = ~clk;

  nand_cmd_seq u0 (.*);

  typedef struct packed {
    logic [63:0] cmd;
    logic [15:0] lat;
    logic [3:0]  we;
    logic [15:0] cle;
    logic        er;
    logic [6:0]  ce;
    logic        w16;
    logic        bo;
  } vec_t;

  localparam int NV = 26;
  localparam vec_t VEC [NV] = '{
    '{64'h0000_0000_00D1_9004, 16'd1,    4'd0, 16'd0,  1'b1, 7'h7F, 1'b0, 1'b0},
    '{64'h15,                  16'd1,    4'd0, 16'd0,  1'b0, 7'h7F, 1'b0, 1'b1},
    '{64'h0000_0000_00D1_9004, 16'd1,    4'd0, 16'd0,  1'b1, 7'h7F, 1'b0, 1'b1},
    '{64'h1A3,                 16'd1,    4'd0, 16'd0,  1'b0, 7'h7D, 1'b0, 1'b1},
    '{64'h0605_0403_0201_0001, 16'd1,    4'd0, 16'd0,  1'b0, 7'h7D, 1'b0, 1'b1},
    '{64'h0000_0000_00D1_9004, 16'd7,    4'd2, 16'd6,  1'b0, 7'h7D, 1'b0, 1'b1},
    '{64'hFF04,                16'd4,    4'd1, 16'd3,  1'b0, 7'h7D, 1'b0, 1'b1},
    '{64'h0000_0000_0147_3004, 16'd14,   4'd1, 16'd13, 1'b0, 7'h7D, 1'b0, 1'b1},
    '{64'h402,                 16'd6,    4'd0, 16'd0,  1'b0, 7'h7D, 1'b0, 1'b1},
    '{64'h002,                 16'd3,    4'd0, 16'd0,  1'b0, 7'h7D, 1'b0, 1'b1},
    '{64'h000,                 16'd1,    4'd0, 16'd0,  1'b0, 7'h7D, 1'b0, 1'b1},
    '{64'h00F,                 16'd1,    4'd0, 16'd0,  1'b1, 7'h7D, 1'b0, 1'b1},
    '{64'h0000_0000_00FF_0021, 16'd1,    4'd0, 16'd0,  1'b0, 7'h7D, 1'b0, 1'b1},
    '{64'h0000_0000_0041_7004, 16'd10,   4'd1, 16'd9,  1'b0, 7'h7D, 1'b0, 1'b1},
    '{64'h202,                 16'd1026, 4'd0, 16'd0,  1'b0, 7'h7D, 1'b0, 1'b1},
    '{64'h123,                 16'd1,    4'd0, 16'd0,  1'b0, 7'h7F, 1'b0, 1'b1},
    '{64'h0000_0000_00D1_9004, 16'd1,    4'd0, 16'd0,  1'b1, 7'h7F, 1'b0, 1'b1},
    '{64'h183,                 16'd1,    4'd0, 16'd0,  1'b0, 7'h7F, 1'b0, 1'b1},
    '{64'h402,                 16'd1,    4'd0, 16'd0,  1'b1, 7'h7F, 1'b0, 1'b1},
    '{64'h2B3,                 16'd1,    4'd0, 16'd0,  1'b0, 7'h7B, 1'b1, 1'b1},
    '{64'h05,                  16'd1,    4'd0, 16'd0,  1'b0, 7'h7B, 1'b1, 1'b0},
    '{64'hFF04,                16'd1,    4'd0, 16'd0,  1'b1, 7'h7B, 1'b1, 1'b0},
    '{64'h15,                  16'd1,    4'd0, 16'd0,  1'b0, 7'h7B, 1'b1, 1'b1},
    '{64'hFF04,                16'd4,    4'd1, 16'd3,  1'b0, 7'h7B, 1'b1, 1'b1},
    '{64'h1F3,                 16'd1,    4'd0, 16'd0,  1'b0, 7'h3F, 1'b0, 1'b1},
    '{64'h009,                 16'd1,    4'd0, 16'd0,  1'b1, 7'h3F, 1'b0, 1'b1}
  };

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic run(input logic [63:0] c, input int rel,
                     output int lat, output int wec, output int clec,
                     output int rdy, output int adbad, output logic e);
    lat = 0; wec = 0; clec = 0; rdy = 0; adbad = 0; e = 1'b0;
    @(negedge clk);
    cmd_data  = c;
    cmd_valid = 1'b1;
    while (!cmd_ready) @(negedge clk);
    @(posedge clk);
    #1 cmd_valid = 1'b0;
    for (int j = 1; j < 5000; j++) begin
      @(negedge clk);
      lat = j;
      if (done) begin
        e = err;
        break;
      end
      if (rel != 0 && j == rel) nand_wait = 1'b0;
      if (!nand_we_n) begin
        wec++;
        if (nand_ad != c[15:8]) adbad++;
      end
      if (nand_cle) clec++;
      if (cmd_ready) rdy++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nbad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end

  initial begin
    int lat, wec, clec, rdy, adbad;
    logic e;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(nand_ce_n == 7'h7F, "R10 ce_n", nand_ce_n, 7'h7F);
    chk(!nand_cle && nand_we_n, "R10 strobes", {nand_cle, nand_we_n}, 2'b01);
    chk(nand_ad == 8'h00, "R10 ad", nand_ad, 0);
    chk(!bus_owned && !busy && cmd_ready && !done && !err, "R10 status",
        {bus_owned, busy, cmd_ready, done, err}, 5'b00100);
    rst_n = 1'b1;

    // R1 R2 R3 R4 R5 R6 R7 R8 R9 table walk
    for (int v = 0; v < NV; v++) begin
      run(VEC[v].cmd, 0, lat, wec, clec, rdy, adbad, e);
      chk(lat == int'(VEC[v].lat), "R2/R3/R4 latency", lat, VEC[v].lat);
      chk(wec == int'(VEC[v].we), "R3 we_n low cycles", wec, VEC[v].we);
      chk(clec == int'(VEC[v].cle), "R3/R7 cle cycles", clec, VEC[v].cle);
      chk(adbad == 0, "R3 ad during we", adbad, 0);
      chk(rdy == 0, "R9 ready while busy", rdy, 0);
      chk(e == VEC[v].er, "R7/R8 err", e, VEC[v].er);
      chk(nand_ce_n == VEC[v].ce, "R5 ce_n", nand_ce_n, VEC[v].ce);
      chk(bus16 == VEC[v].w16, "R5 bus16", bus16, VEC[v].w16);
      chk(bus_owned == VEC[v].bo, "R6 bus_owned", bus_owned, VEC[v].bo);
      @(negedge clk);
      chk(!done, "R9 done single pulse", done, 0);
    end

    // R4 ready/busy flag set, line already low: same as flag clear
    nand_wait = 1'b0;
    run(64'h12, 0, lat, wec, clec, rdy, adbad, e);
    chk(lat == 3, "R4 rb wait line low", lat, 3);

    // R4 line held busy, released at cycle 10
    nand_wait = 1'b1;
    fork
      run(64'h12, 10, lat, wec, clec, rdy, adbad, e);
      begin
        repeat (6) @(negedge clk);
        chk(busy, "R9 busy during rb wait", busy, 1);
      end
    join
    chk(lat == 11, "R4 rb wait release", lat, 11);
    chk(wec == 0 && clec == 0, "R4 no strobe in wait", wec + clec, 0);
    chk(!e, "R4 no err", e, 0);

    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end
endmodule